// File: doc/BRIEF.md
# Two-Wire Converter Read Controller

This block sits on the host side of a serial analog-to-digital converter that has only two signals: a serial clock that the host drives and a single return line from the converter. The return line does two jobs. While no frame is in progress it goes low to show that a fresh conversion is waiting. During a frame it carries the result bits. The converter has no chip select. Every command beyond a plain read is given by the number of clock pulses in a frame, or by leaving the clock parked high.

The host side issues one of four commands over a valid/ready pair. A plain read waits for the ready-low condition and then clocks a 24-pulse frame. The 20-bit two's-complement result comes in most significant bit first, and one extra pulse returns the line high. The calibrating read adds a second extra pulse, then waits for the line to fall again before it reports that calibration is complete. A sleep command waits for ready and then holds the clock high. A wake command drops the clock again. The serial clock comes from the system clock, with each phase lasting a set number of system cycles. A programmable timeout ends any wait that the converter does not answer.

Top module: `twoWireAdcReader`

## Requirements
- R1: After reset, sclkOut is low, cmdReady is high, and sleeping, resValid, calDone and timeoutErr are all low.
- R2: A read command produces no clock pulse while the synchronized return line is high. The frame starts only once the line is seen low with the clock low.
- R3: A read with cmdOp 0 produces exactly 25 clock pulses. The bit on the line at the end of the high phase of pulses 1 to 20 becomes result bits 19 down to 0, in that order.
- R4: A read with cmdOp 1 produces exactly 26 clock pulses. After that, calDone pulses for one cycle once the line is seen low again, and never before.
- R5: Every high phase of the serial clock lasts exactly DIV_HALF system cycles, except when it ends a sleep. Every low phase between two pulses of a frame also lasts exactly DIV_HALF cycles.
- R6: resValid is high for one cycle, DIV_HALF cycles after the last falling clock edge of the frame. resData then holds the 20-bit result sign-extended to 32 bits.
- R7: If the line is not seen low within timeoutLimit+1 cycles of entering a wait, timeoutErr pulses for one cycle and the block returns to idle without producing a clock pulse or a result.
- R8: A sleep command (cmdOp 2) waits for the line to be low. It then raises the clock, holds it high and asserts sleeping.
- R9: A wake command (cmdOp 3) given while sleeping drops the clock, clears sleeping and returns to idle.
- R10: Read and sleep commands accepted while sleeping are dropped and the clock stays high. A wake command accepted while idle is dropped and the clock stays low.
- R11: cmdReady is high only while idle or sleeping.
- R12: At most one of resValid, calDone and timeoutErr is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 2 | Command code: 0 read, 1 read with calibration, 2 sleep, 3 wake |
| cmdReady | output | 1 | Command is accepted on a cycle where this and cmdValid are both high |
| timeoutLimit | input | TMO_W | Wait limit in system cycles |
| sclkOut | output | 1 | Serial clock to the converter |
| rdyDataIn | input | 1 | Combined ready and data line from the converter |
| resValid | output | 1 | One-cycle result strobe |
| resData | output | OUT_W | Sign-extended conversion result |
| calDone | output | 1 | One-cycle strobe when calibration is complete |
| timeoutErr | output | 1 | One-cycle strobe when a wait times out |
| sleeping | output | 1 | Clock is parked high and the converter is asleep |

## Verification
The hardest case to reach from the ports is the calibration wait. It needs a converter that counts the clock pulses, drives the bits on each rising edge, raises the line after the frame and then holds it high. The bench contains a behavioural converter model that responds to the generated clock. It lets the bench delay the fall of the line well after the 26th pulse, which shows that the completion strobe waits for that fall. The sleep entry is exercised with the line first high and then low, and commands are sent while the clock is parked, to show they have no effect.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

  typedef enum logic [1:0] {
    OP_READ     = 2'd0,
    OP_READ_CAL = 2'd1,
    OP_SLEEP    = 2'd2,
    OP_WAKE     = 2'd3
  } adcOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic sclkSet;
    logic sclkClr;
    logic phaseRun;
    logic sampleBit;
    logic clearShift;
    logic emitResult;
    logic tmoClear;
    logic tmoRun;
  } dpStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic dataLow;
    logic phaseEnd;
    logic tmoHit;
  } dpStatus_t;

endpackage

// File: rtl/adcrd_dpath.sv
module adcrd_dpath
  import adcrd_pkg::*;
#(
  parameter int DIV_HALF    = 5,
  parameter int RES_BITS    = 20,
  parameter int OUT_W       = 32,
  parameter int TMO_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  output dpStatus_t        stat,
  input  logic             rdyDataIn,
  input  logic [TMO_W-1:0] timeoutLimit,
  output logic             sclkOut,
  output logic             resValid,
  output logic [OUT_W-1:0] resData
);

  localparam int PH_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV_HALF - 1);

  logic                lineNow;
  logic [PH_W-1:0]     phaseCnt;
  logic [RES_BITS-1:0] shiftReg;
  logic [TMO_W-1:0]    tmoCnt;
  logic [OUT_W-1:0]    extWord;

  // input synchronizer, idles high like the line
  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic syncQ;
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= 1'b1;
        else       syncQ <= rdyDataIn;
      end
      assign lineNow = syncQ;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rdyDataIn};
      end
      assign lineNow = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  // serial clock register
  always_ff @(posedge clk) begin
    if (!rstN)             sclkOut <= 1'b0;
    else if (strb.sclkSet) sclkOut <= 1'b1;
    else if (strb.sclkClr) sclkOut <= 1'b0;
  end

  // phase divider
  always_ff @(posedge clk) begin
    if (!rstN || !strb.phaseRun) phaseCnt <= '0;
    else if (phaseCnt == PH_LAST) phaseCnt <= '0;
    else                          phaseCnt <= phaseCnt + 1'b1;
  end

  // result shift register, most significant bit arrives first
  always_ff @(posedge clk) begin
    if (!rstN || strb.clearShift) shiftReg <= '0;
    else if (strb.sampleBit)      shiftReg <= {shiftReg[RES_BITS-2:0], lineNow};
  end

  // sign extension variant picked by width
  generate
    if (OUT_W > RES_BITS) begin : g_ext
      assign extWord = {{(OUT_W-RES_BITS){shiftReg[RES_BITS-1]}}, shiftReg};
    end else begin : g_noext
      assign extWord = shiftReg;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData  <= '0;
      resValid <= 1'b0;
    end else begin
      resValid <= strb.emitResult;
      if (strb.emitResult) resData <= extWord;
    end
  end

  // wait timer
  always_ff @(posedge clk) begin
    if (!rstN || strb.tmoClear) tmoCnt <= '0;
    else if (strb.tmoRun)       tmoCnt <= tmoCnt + 1'b1;
  end

  assign stat.dataLow  = !lineNow;
  assign stat.phaseEnd = strb.phaseRun && (phaseCnt == PH_LAST);
  assign stat.tmoHit   = strb.tmoRun && (tmoCnt == timeoutLimit);

endmodule

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int RES_BITS     = 20,
  parameter int FRAME_PULSES = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  output logic       cmdReady,
  output logic       sleeping,
  output logic       calDone,
  output logic       timeoutErr,
  input  dpStatus_t  stat,
  output dpStrobe_t  strb
);

  localparam int PC_W = $clog2(FRAME_PULSES + 3);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_RDY, S_HI, S_LO, S_CAL_WAIT, S_SLEEP_WAIT, S_ASLEEP
  } state_e;

  state_e          state, nxt;
  logic [PC_W-1:0] pulseCnt;
  logic [PC_W-1:0] lastIdx;
  logic            withCal;
  logic            accept;
  logic            raiseCal;
  logic            raiseTmo;
  logic            isReadOp;

  assign cmdReady = (state == S_IDLE) || (state == S_ASLEEP);
  assign sleeping = (state == S_ASLEEP);
  assign accept   = cmdValid && cmdReady;
  assign isReadOp = (cmdOp == OP_READ) || (cmdOp == OP_READ_CAL);
  // index of the final pulse: one extra after the frame, two with calibration
  assign lastIdx  = withCal ? PC_W'(FRAME_PULSES + 1) : PC_W'(FRAME_PULSES);

  always_comb begin
    nxt      = state;
    strb     = '0;
    raiseCal = 1'b0;
    raiseTmo = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (accept && isReadOp) begin
          strb.tmoClear   = 1'b1;
          strb.clearShift = 1'b1;
          nxt             = S_WAIT_RDY;
        end else if (accept && cmdOp == OP_SLEEP) begin
          strb.tmoClear = 1'b1;
          nxt           = S_SLEEP_WAIT;
        end
      end
      S_WAIT_RDY: begin
        strb.tmoRun = 1'b1;
        if (stat.dataLow) begin
          strb.sclkSet = 1'b1;
          nxt          = S_HI;
        end else if (stat.tmoHit) begin
          raiseTmo = 1'b1;
          nxt      = S_IDLE;
        end
      end
      S_HI: begin
        strb.phaseRun = 1'b1;
        if (stat.phaseEnd) begin
          strb.sclkClr   = 1'b1;
          strb.sampleBit = (pulseCnt < PC_W'(RES_BITS));
          nxt            = S_LO;
        end
      end
      S_LO: begin
        strb.phaseRun = 1'b1;
        if (stat.phaseEnd) begin
          if (pulseCnt == lastIdx) begin
            strb.emitResult = 1'b1;
            strb.tmoClear   = 1'b1;
            nxt             = withCal ? S_CAL_WAIT : S_IDLE;
          end else begin
            strb.sclkSet = 1'b1;
            nxt          = S_HI;
          end
        end
      end
      S_CAL_WAIT: begin
        strb.tmoRun = 1'b1;
        if (stat.dataLow) begin
          raiseCal = 1'b1;
          nxt      = S_IDLE;
        end else if (stat.tmoHit) begin
          raiseTmo = 1'b1;
          nxt      = S_IDLE;
        end
      end
      S_SLEEP_WAIT: begin
        strb.tmoRun = 1'b1;
        if (stat.dataLow) begin
          strb.sclkSet = 1'b1;
          nxt          = S_ASLEEP;
        end else if (stat.tmoHit) begin
          raiseTmo = 1'b1;
          nxt      = S_IDLE;
        end
      end
      S_ASLEEP: begin
        if (accept && cmdOp == OP_WAKE) begin
          strb.sclkClr = 1'b1;
          nxt          = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      pulseCnt   <= '0;
      withCal    <= 1'b0;
      calDone    <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      state      <= nxt;
      calDone    <= raiseCal;
      timeoutErr <= raiseTmo;
      if (state == S_IDLE && accept && isReadOp) begin
        pulseCnt <= '0;
        withCal  <= (cmdOp == OP_READ_CAL);
      end else if (state == S_LO && stat.phaseEnd) begin
        pulseCnt <= pulseCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/twoWireAdcReader.sv
module twoWireAdcReader
  import adcrd_pkg::*;
#(
  parameter int DIV_HALF     = 5,
  parameter int RES_BITS     = 20,
  parameter int FRAME_PULSES = 24,
  parameter int OUT_W        = 32,
  parameter int TMO_W        = 24,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  output logic             cmdReady,
  input  logic [TMO_W-1:0] timeoutLimit,
  output logic             sclkOut,
  input  logic             rdyDataIn,
  output logic             resValid,
  output logic [OUT_W-1:0] resData,
  output logic             calDone,
  output logic             timeoutErr,
  output logic             sleeping
);

  dpStrobe_t strb;
  dpStatus_t stat;

  adcrd_ctrl #(
    .RES_BITS    (RES_BITS),
    .FRAME_PULSES(FRAME_PULSES)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .cmdReady  (cmdReady),
    .sleeping  (sleeping),
    .calDone   (calDone),
    .timeoutErr(timeoutErr),
    .stat      (stat),
    .strb      (strb)
  );

  adcrd_dpath #(
    .DIV_HALF   (DIV_HALF),
    .RES_BITS   (RES_BITS),
    .OUT_W      (OUT_W),
    .TMO_W      (TMO_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .stat        (stat),
    .rdyDataIn   (rdyDataIn),
    .timeoutLimit(timeoutLimit),
    .sclkOut     (sclkOut),
    .resValid    (resValid),
    .resData     (resData)
  );

endmodule

// File: rtl/adcrd_checker.sv
module adcrd_checker #(
  parameter int DIV_HALF = 5
) (
  input logic clk,
  input logic rstN,
  input logic cmdReady,
  input logic sclkOut,
  input logic sleeping,
  input logic resValid,
  input logic calDone,
  input logic timeoutErr
);

  int hiCnt;

  always_ff @(posedge clk) begin
    if (!rstN)        hiCnt <= 0;
    else if (sclkOut) hiCnt <= hiCnt + 1;
    else              hiCnt <= 0;
  end

  // R5: clock idles low whenever idle
  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReady && !sleeping) |-> !sclkOut);

  // R5: a high phase that does not end a sleep lasts DIV_HALF cycles
  a_r5_high_width: assert property (@(posedge clk) disable iff (!rstN)
    (!sclkOut && $past(sclkOut) && !$past(sleeping)) |-> (hiCnt == DIV_HALF));

  // R8: the clock is parked high while asleep
  a_r8_sleep_high: assert property (@(posedge clk) disable iff (!rstN)
    sleeping |-> sclkOut);

  // R9: leaving sleep drops the clock
  a_r9_wake_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleeping) |-> !sclkOut);

  // R6: single-cycle result strobe
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  // R11: no commands are taken while a pulse is high
  a_r11_busy: assert property (@(posedge clk) disable iff (!rstN)
    (sclkOut && !sleeping) |-> !cmdReady);

  // R12: completion strobes are exclusive
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resValid, calDone, timeoutErr}));

endmodule

bind twoWireAdcReader adcrd_checker #(.DIV_HALF(DIV_HALF)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdReady  (cmdReady),
  .sclkOut   (sclkOut),
  .sleeping  (sleeping),
  .resValid  (resValid),
  .calDone   (calDone),
  .timeoutErr(timeoutErr)
);

// File: tb/sim_twoWireAdcReader.sv
module sim_twoWireAdcReader;

  localparam int DIV_HALF = 5;
  localparam int RES = 20;
  localparam int TMO_W = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic cmdReady;
  logic [TMO_W-1:0] timeoutLimit = TMO_W'(5000);
  logic sclkOut;
  logic adcLine = 1'b1;
  logic resValid;
  logic [31:0] resData;
  logic calDone;
  logic timeoutErr;
  logic sleeping;

  always #10 clk = ~clk;

  twoWireAdcReader u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdReady(cmdReady), .timeoutLimit(timeoutLimit), .sclkOut(sclkOut),
    .rdyDataIn(adcLine), .resValid(resValid), .resData(resData),
    .calDone(calDone), .timeoutErr(timeoutErr), .sleeping(sleeping)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural converter model
  logic [RES-1:0] adcWord = '0;
  bit modelOn = 0;
  int rises = 0;

  always @(posedge sclkOut) begin
    if (modelOn) begin
      rises = rises + 1;
      if (rises <= RES)     adcLine <= adcWord[RES-rises];
      else if (rises <= 24) adcLine <= 1'b0;
      else                  adcLine <= 1'b1;
    end
  end

  // observation of the ports, away from the active edge
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit prevSclk = 0, prevSleep = 0;
  int hiRun = 0, loRun = 0, badPhase = 0, allRises = 0;
  int lastFallCyc = 0, resCyc = 0, resSeen = 0, calSeen = 0;
  int tmoSeen = 0, tmoCyc = 0, sleepLow = 0, idleHigh = 0;
  logic [31:0] resVal = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (sclkOut && !prevSclk) begin
        allRises++;
        if (modelOn && rises >= 2 && loRun != DIV_HALF) badPhase++;
      end
      if (!sclkOut && prevSclk) begin
        lastFallCyc = cyc;
        if (!prevSleep && hiRun != DIV_HALF) badPhase++;
      end
      if (resValid) begin resSeen++; resCyc = cyc; resVal = resData; end
      if (calDone) calSeen++;
      if (timeoutErr) begin tmoSeen++; tmoCyc = cyc; end
      if (sleeping && !sclkOut) sleepLow++;
      if (cmdReady && !sleeping && sclkOut) idleHigh++;
    end
    hiRun = sclkOut ? (prevSclk ? hiRun + 1 : 1) : 0;
    loRun = !sclkOut ? (!prevSclk ? loRun + 1 : 1) : 0;
    prevSclk = sclkOut;
    prevSleep = sleeping;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] signExt(input logic [RES-1:0] w);
    return {{(32-RES){w[RES-1]}}, w};
  endfunction

  task automatic issue(input logic [1:0] op);
    @(negedge clk);
    cmdOp = op;
    cmdValid = 1'b1;
    @(posedge clk);
    #1;
    cmdValid = 1'b0;
  endtask

  task automatic doRead(input logic [RES-1:0] word, input bit cal, input int preDelay);
    int r0, c0, a0;
    adcWord = word;
    rises = 0;
    modelOn = 1;
    adcLine = (preDelay > 0);
    r0 = resSeen; c0 = calSeen; a0 = allRises;
    issue(cal ? 2'd1 : 2'd0);
    if (preDelay > 0) begin
      repeat (preDelay) @(negedge clk);
      check(allRises == a0, "R2 no pulse while line high", allRises - a0, 0);
      adcLine = 1'b0;
    end
    for (int i = 0; i < 3000 && resSeen == r0; i++) @(negedge clk);
    check(resSeen == r0 + 1, "R6 result strobe", resSeen - r0, 1);
    check(resVal == signExt(word), "R3 R6 result value", resVal, signExt(word));
    if (cal) check(rises == 26, "R4 pulse count", rises, 26);
    else     check(rises == 25, "R3 pulse count", rises, 25);
    check(resCyc - lastFallCyc == DIV_HALF, "R6 strobe latency", resCyc - lastFallCyc, DIV_HALF);
    if (cal) begin
      repeat (40) @(negedge clk);
      check(calSeen == c0, "R4 no early calDone", calSeen - c0, 0);
      adcLine = 1'b0;
      repeat (6) @(negedge clk);
      check(calSeen == c0 + 1, "R4 calDone after line low", calSeen - c0, 1);
    end else begin
      repeat (3) @(negedge clk);
      check(cmdReady && !sclkOut, "R11 idle after read", {cmdReady, sclkOut}, 2'b10);
    end
    modelOn = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int a0, t0, cE, r0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(sclkOut == 0 && cmdReady == 1 && sleeping == 0, "R1 reset outputs",
          {sclkOut, cmdReady, sleeping}, 3'b010);
    check(resValid == 0 && calDone == 0 && timeoutErr == 0, "R1 reset strobes",
          {resValid, calDone, timeoutErr}, 0);

    // R3 R6 several data patterns
    doRead(20'h5A5A5, 0, 0);
    doRead(20'h80001, 0, 0);
    doRead(20'hFFFFF, 0, 0);
    doRead(20'h7FFFF, 0, 0);
    // R2 ready arrives late
    doRead(20'h12345, 0, 60);
    // R4 calibrating read
    doRead(20'hC3A10, 1, 0);
    doRead(20'h00000, 0, 0);

    // R7 timeout with the line held high
    timeoutLimit = TMO_W'(30);
    adcLine = 1'b1;
    repeat (5) @(negedge clk);
    a0 = allRises; t0 = tmoSeen; r0 = resSeen;
    issue(2'd0);
    cE = cyc;
    for (int i = 0; i < 200 && tmoSeen == t0; i++) @(negedge clk);
    check(tmoSeen == t0 + 1, "R7 timeout strobe", tmoSeen - t0, 1);
    check(tmoCyc - cE == 31, "R7 timeout delay", tmoCyc - cE, 31);
    check(allRises == a0 && resSeen == r0, "R7 no pulse no result", allRises - a0, 0);
    @(negedge clk);
    check(cmdReady == 1, "R7 back to idle", cmdReady, 1);
    timeoutLimit = TMO_W'(5000);

    // R10 wake in idle is dropped
    a0 = allRises;
    issue(2'd3);
    repeat (10) @(negedge clk);
    check(cmdReady && !sclkOut && !sleeping && allRises == a0, "R10 wake in idle dropped",
          {cmdReady, sclkOut, sleeping}, 3'b100);

    // R8 sleep waits for the line to go low
    adcLine = 1'b1;
    issue(2'd2);
    repeat (20) @(negedge clk);
    check(!sclkOut && !sleeping, "R8 sleep waits for ready", {sclkOut, sleeping}, 0);
    check(cmdReady == 0, "R11 busy during sleep wait", cmdReady, 0);
    adcLine = 1'b0;
    repeat (6) @(negedge clk);
    check(sclkOut && sleeping, "R8 asleep with clock high", {sclkOut, sleeping}, 2'b11);
    repeat (100) @(negedge clk);
    check(sclkOut && sleepLow == 0, "R8 clock held high", sleepLow, 0);

    // R10 read while asleep is dropped
    r0 = resSeen;
    issue(2'd0);
    repeat (30) @(negedge clk);
    check(sclkOut && sleeping && resSeen == r0, "R10 read while asleep dropped",
          {sclkOut, sleeping}, 2'b11);

    // R9 wake
    adcLine = 1'b1;
    issue(2'd3);
    repeat (2) @(negedge clk);
    check(!sclkOut && !sleeping && cmdReady, "R9 wake returns to idle",
          {sclkOut, sleeping, cmdReady}, 3'b001);

    // read after wake
    doRead(20'hABCDE, 0, 20);

    // R5 phase widths across the run
    check(badPhase == 0, "R5 phase widths", badPhase, 0);
    check(idleHigh == 0, "R5 idle clock low", idleHigh, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule